// File: doc/BRIEF.md
# Reloading Up/Down Duty Counter

This block is an 8-bit counter that starts from a programmable start value, steps by one on every clock edge toward a terminal value, and then loads the start value again. Each time it reaches the terminal value it raises a registered pulse for one clock. By default it counts down toward zero. A direction input makes it count up toward 255 instead. A hold input freezes the count, and a load input forces the start value back into the count.

The live count is always present on an 8-bit output. It is meant to feed the duty-cycle word of a pulse-width generator elsewhere on the chip, so changing direction or holding the count slides or fixes that duty cycle. The start value is read only when the count is loaded. A new start value therefore takes effect at the next load or wrap, and does not disturb a count already in progress.

Top module: `reload_counter`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, `count` takes the value of `ctrl_val` after that edge and `term_pulse` is 0.
- R2: With `reload`, `hold` and `dir_up` low and `count` above 1, each rising edge lowers `count` by exactly one and leaves `term_pulse` at 0.
- R3: With `reload`, `hold` and `dir_up` low and `count` at 1 or 0, the next edge loads `ctrl_val` into `count` and sets `term_pulse` to 1 for that cycle. With a start value of 3 and the count running freely, the pulse repeats every 3 clocks and is one clock wide.
- R4: With `dir_up` high, `reload` and `hold` low and `count` below 254, each rising edge raises `count` by exactly one and leaves `term_pulse` at 0.
- R5: With `dir_up` high, `reload` and `hold` low and `count` at 254 or 255, the next edge loads `ctrl_val` and sets `term_pulse` to 1, so the up period is 255 minus the start value.
- R6: With `hold` high and `reload` low, `count` keeps its value at every edge and `term_pulse` is 0.
- R7: With `reload` high, the next edge loads `ctrl_val` into `count` and clears `term_pulse`, whatever `hold` and `dir_up` are. Loading takes priority over holding, and holding takes priority over counting.
- R8: A change of `ctrl_val` while the counter steps freely has no effect on `count` until the next load or wrap. That load then uses the new value.
- R9: A change of `dir_up` in the middle of a count continues from the current `count` value in the new direction, with no reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the start value |
| ctrl_val | input | 8 | Programmable start value |
| dir_up | input | 1 | 1 = count up toward 255, 0 = count down toward 0 |
| hold | input | 1 | 1 = freeze the count |
| reload | input | 1 | 1 = load the start value at the next edge |
| term_pulse | output | 1 | One-clock registered pulse on reaching the terminal value |
| count | output | 8 | Live count, meant as a duty-cycle word |

## Verification
Both outputs are registered, so every result belongs to the rising edge that follows the stimulus and is due exactly one clock after it. The driver changes the inputs on the falling edge and pushes the count and pulse it expects after the next rising edge into a queue. The monitor pops one item per rising edge and compares it 1 ns after that edge, so each comparison lines up with the single edge that produced the result. Holding, priority, a changed start value and a direction change are each checked across several following cycles, which shows that a count left unchanged or unaffected stays so until the next load.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    localparam int CNT_W = 8;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_ONE  = cnt_t'(1);
    localparam cnt_t CNT_ZERO = cnt_t'(0);
    localparam cnt_t CNT_TOP  = {CNT_W{1'b1}};
    localparam cnt_t CNT_NEAR = CNT_TOP - CNT_ONE;

    // Action selected for the next edge, highest priority first
    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_STEP = 2'd2
    } op_e;

    typedef struct packed {
        cnt_t value;
        logic pulse;
    } cnt_state_t;

    // True when one more step would reach (or pass) the terminal value
    function automatic logic at_terminal(input cnt_t v, input logic up);
        if (up) begin
            return (v >= CNT_NEAR);
        end
        return (v <= CNT_ONE);
    endfunction

endpackage

// File: rtl/rlc_arbiter.sv
module rlc_arbiter
    import rlc_pkg::*;
(
    input  logic sys_rst,
    input  logic load_req,
    input  logic hold_req,
    output op_e  op
);

    always_comb begin
        if (sys_rst || load_req) begin
            op = OP_LOAD;
        end else if (hold_req) begin
            op = OP_HOLD;
        end else begin
            op = OP_STEP;
        end
    end

endmodule

// File: rtl/rlc_stepper.sv
module rlc_stepper
    import rlc_pkg::*;
(
    input  cnt_t cur,
    input  logic up,
    output cnt_t nxt,
    output logic hit
);

    always_comb begin
        nxt = up ? (cur + CNT_ONE) : (cur - CNT_ONE);
        hit = at_terminal(cur, up);
    end

endmodule

// File: rtl/rlc_state_reg.sv
module rlc_state_reg
    import rlc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  op_e        op,
    input  cnt_t       start_val,
    input  cnt_t       step_val,
    input  logic       step_hit,
    output cnt_state_t st
);

    always_ff @(posedge clk) begin
        case (op)
            OP_LOAD: begin
                st.value <= start_val;
                st.pulse <= 1'b0;
            end
            OP_STEP: begin
                if (step_hit) begin
                    st.value <= start_val;
                    st.pulse <= 1'b1;
                end else begin
                    st.value <= step_val;
                    st.pulse <= 1'b0;
                end
            end
            default: begin
                st.pulse <= 1'b0;
            end
        endcase
    end

    AST_RESET_LOAD: assert property (@(posedge clk)
        rst |=> (st.value == $past(start_val)) && !st.pulse); // R1

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> (st.value == $past(st.value)) && !st.pulse); // R6

endmodule

// File: rtl/reload_counter.sv
module reload_counter
    import rlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] ctrl_val,
    input  logic             dir_up,
    input  logic             hold,
    input  logic             reload,
    output logic             term_pulse,
    output logic [CNT_W-1:0] count
);

    op_e        op;
    cnt_t       step_val;
    logic       step_hit;
    cnt_state_t st;

    rlc_arbiter u_arb (
        .sys_rst  (rst),
        .load_req (reload),
        .hold_req (hold),
        .op       (op)
    );

    rlc_stepper u_step (
        .cur (st.value),
        .up  (dir_up),
        .nxt (step_val),
        .hit (step_hit)
    );

    rlc_state_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .start_val (ctrl_val),
        .step_val  (step_val),
        .step_hit  (step_hit),
        .st        (st)
    );

    assign count      = st.value;
    assign term_pulse = st.pulse;

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
        (!reload && !hold && !dir_up && count > CNT_ONE)
        |=> (count == $past(count) - CNT_ONE) && !term_pulse); // R2

    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!reload && !hold && !dir_up && count <= CNT_ONE)
        |=> (count == $past(ctrl_val)) && term_pulse); // R3

    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (!reload && !hold && dir_up && count < CNT_NEAR)
        |=> (count == $past(count) + CNT_ONE) && !term_pulse); // R4

    AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!reload && !hold && dir_up && count >= CNT_NEAR)
        |=> (count == $past(ctrl_val)) && term_pulse); // R5

    AST_LOAD_FIRST: assert property (@(posedge clk) disable iff (rst)
        reload |=> (count == $past(ctrl_val)) && !term_pulse); // R7

endmodule

// File: tb/test_reload_counter.sv
`timescale 1ns/1ps
module test_reload_counter;
    import rlc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    cnt_t ctrl_val = cnt_t'(3);
    logic dir_up = 1'b0;
    logic hold = 1'b0;
    logic reload = 1'b0;
    logic term_pulse;
    cnt_t count;

    always #2 clk = ~clk;

    reload_counter i_reload_counter (
        .clk        (clk),
        .rst        (rst),
        .ctrl_val   (ctrl_val),
        .dir_up     (dir_up),
        .hold       (hold),
        .reload     (reload),
        .term_pulse (term_pulse),
        .count      (count)
    );

    typedef struct {
        cnt_t  cnt;
        logic  pls;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    cnt_t m_cnt  = '0;

    // Driver: apply one cycle of stimulus and queue the result due after the next edge
    task automatic drive(input logic r, input cnt_t c, input logic up,
                         input logic kp, input logic ld, input string tag);
        exp_t e;
        logic p;
        @(negedge clk);
        rst = r; ctrl_val = c; dir_up = up; hold = kp; reload = ld;
        p = 1'b0;
        if (r || ld) begin
            m_cnt = c;
        end else if (kp) begin
            m_cnt = m_cnt;
        end else if (up) begin
            if (m_cnt >= 8'd254) begin m_cnt = c; p = 1'b1; end
            else m_cnt = m_cnt + 8'd1;
        end else begin
            if (m_cnt <= 8'd1) begin m_cnt = c; p = 1'b1; end
            else m_cnt = m_cnt - 8'd1;
        end
        e.cnt = m_cnt; e.pls = p; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic run(input int n, input cnt_t c, input logic up, input string tag);
        for (int i = 0; i < n; i++) drive(1'b0, c, up, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare one queued item 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (count !== e.cnt || term_pulse !== e.pls) begin
                n_fail++;
                $display("FAIL %s: count=%0d pulse=%0b, expected count=%0d pulse=%0b",
                         e.tag, count, term_pulse, e.cnt, e.pls);
            end
        end
    end

    bit done = 1'b0;

    initial begin
        drive(1'b1, 8'd3, 1'b0, 1'b0, 1'b0, "R1 reset loads start");
        drive(1'b1, 8'd3, 1'b0, 1'b0, 1'b0, "R1 reset held");
        run(2, 8'd3, 1'b0, "R2 down step");
        run(9, 8'd3, 1'b0, "R3 wrap every 3 clocks");
        // hold with pulse due next: stays frozen, no pulse
        for (int i = 0; i < 4; i++) drive(1'b0, 8'd3, 1'b0, 1'b1, 1'b0, "R6 hold freezes");
        for (int i = 0; i < 2; i++) drive(1'b0, 8'd3, 1'b1, 1'b1, 1'b0, "R6 hold ignores direction");
        run(3, 8'd3, 1'b0, "R3 after hold");
        // reload wins over hold
        drive(1'b0, 8'd40, 1'b0, 1'b1, 1'b1, "R7 reload over hold");
        drive(1'b0, 8'd40, 1'b1, 1'b0, 1'b1, "R7 reload while up");
        run(5, 8'd40, 1'b0, "R2 down from 40");
        // start value change mid count
        run(30, 8'd7, 1'b0, "R8 new start waits");
        run(9, 8'd7, 1'b0, "R8 new start used");
        // direction change mid count
        drive(1'b0, 8'd7, 1'b0, 1'b0, 1'b1, "R7 reload 7");
        run(2, 8'd7, 1'b0, "R9 down before turn");
        run(3, 8'd7, 1'b1, "R9 up from current");
        run(2, 8'd7, 1'b0, "R9 down again");
        // up mode near top
        drive(1'b0, 8'd250, 1'b1, 1'b0, 1'b1, "R7 reload 250");
        run(3, 8'd250, 1'b1, "R4 up step");
        run(12, 8'd250, 1'b1, "R5 up wrap period 5");
        drive(1'b0, 8'd255, 1'b1, 1'b0, 1'b1, "R7 reload 255");
        run(3, 8'd255, 1'b1, "R5 at 255 pulses each clock");
        // start value of zero going down
        drive(1'b0, 8'd0, 1'b0, 1'b0, 1'b1, "R7 reload 0");
        run(3, 8'd0, 1'b0, "R3 zero start pulses each clock");
        drive(1'b1, 8'd9, 1'b1, 1'b1, 1'b1, "R1 reset mid run");
        run(3, 8'd9, 1'b0, "R2 after reset");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule